// File: doc/BRIEF.md
# Shared Flash and Modem Local Bus Master

This block drives byte-wide read and write cycles on a local bus that is shared between a parallel flash memory and a modem peripheral. One pin set serves both devices: an address bus, an 8-bit data bus with a separate output enable, an active-low chip select, an active-low read strobe and an active-low write strobe. There is no programming-voltage output, so the write strobe alone gates writes. Internal logic makes a request with an address, write data and a direction flag. The block then sequences the pins and reports completion with a one-cycle done pulse, which on reads comes with the captured byte.

Every interval is a parameter in nanoseconds that is turned into cycles of the reference clock. The default period is 40 ns. Each interval is rounded up, so no device minimum is broken. The sequence runs through set-up, strobe, hold and recovery phases. When the modem-mode input is high, one address pin (bit 8 by default) stops driving and serves as an asynchronous ready input. That input passes through a two-stage synchronizer, and while the synchronized ready is low the active strobe stays asserted past its minimum length.

Top module: `flbus_ctrl`

## Requirements
- R1: Out of reset, chip select, read strobe and write strobe are high (inactive), the data bus is not driven, and busy, done and rd_data are 0.
- R2: A request is taken only when busy is 0. A request raised while a cycle runs is dropped: the address pins keep the value of the running cycle and only one done pulse follows.
- R3: On a read accepted at clock edge k, chip select goes low after edge k. The read strobe is low from edge k+1 to edge k+4 (3 cycles). The data bus input is captured into rd_data at edge k+4, so a value applied in the last strobe cycle is returned and a later change is not.
- R4: During a read the data bus is never driven. The read strobe and data-bus drive are never active together. Chip select rises one cycle after the read strobe, and done follows 3 cycles after the read strobe rises (done high after edge k+7).
- R5: On a write accepted at edge k, chip select and the data bus (driving the request's write data) become active after edge k. The write strobe is low for exactly 3 cycles starting after edge k+1. Chip select and data drive stay active one cycle after the write strobe rises. The two strobes are never low together.
- R6: On a write, done is high after edge k+6. The address pins hold the last accepted address until the next request is accepted, including the idle cycles after done.
- R7: Done is a single-cycle pulse per completed cycle, and busy is 1 from acceptance until the cycle in which done is high.
- R8: With modem_mode high, the pin-drive enable of address bit 8 is 0, and that bit of bus_addr_o is 0. While the ready input is low, the strobe stays low. It is released at the third clock edge after the ready input is seen high at a falling clock edge.
- R9: With modem_mode low, address bit 8 is driven with bit 8 of the request address, its pin-drive enable is 1, and the ready input has no effect on strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| modem_mode | input | 1 | 1 selects modem mode (address bit 8 becomes ready) |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte |
| bus_addr_o | output | 17 | Address pins |
| bus_rdy_pin_oe | output | 1 | Drive enable for the shared address/ready pin |
| bus_rdy_i | input | 1 | Ready input from the shared pin (asynchronous) |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_dq_o | output | 8 | Data bus output value |
| bus_dq_oe | output | 1 | Data bus drive enable |
| bus_dq_i | input | 8 | Data bus input value |

## Verification
All pin changes follow a clock edge counted from the accepting edge k. Chip select follows edge k and a strobe follows edge k+1. Read capture is at edge k+4, and done comes after edge k+7 for a read or edge k+6 for a write. A stretched strobe ends three edges after ready is raised. The bench raises a request at a falling edge and then samples every output at each following falling edge, numbering those samples from 1. It compares the first and last sample index of each pin's active window with those edge counts, which it derives from the nanosecond limits itself. Data-bus input changes are placed at specific samples, so a check shows exactly which edge did the capture.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } phase_t;

  // Round a nanosecond limit up to whole clock periods.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles left of a total after a part already spent, never below one.
  function automatic int unsigned remain(input int unsigned total, input int unsigned spent);
    return (total > spent) ? (total - spent) : 1;
  endfunction

endpackage

// File: rtl/fbc_rdy_sync.sv
module fbc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/fbc_timer.sv
module fbc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/fbc_seq.sv
module fbc_seq
  import fbc_pkg::*;
#(
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_RDS   = 3,
  parameter int unsigned T_WRS   = 3,
  parameter int unsigned T_HOLD  = 1,
  parameter int unsigned T_RREC  = 2,
  parameter int unsigned T_WREC  = 1,
  parameter int          W       = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  input  logic   modem,
  input  logic   rdy_s,
  output phase_t phase_o,
  output logic   wr_o,
  output logic   sample_o,
  output logic   done_o,
  output logic   busy_o
);
  phase_t       phase, nxt;
  logic         wr_q, done_q;
  logic         load, zero;
  logic [W-1:0] len;

  fbc_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .len(len), .zero(zero)
  );

  always_comb begin
    nxt  = phase;
    load = 1'b0;
    len  = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        nxt = PH_SETUP; load = 1'b1; len = W'(T_SETUP);
      end
      PH_SETUP: if (zero) begin
        nxt = PH_STROBE; load = 1'b1; len = wr_q ? W'(T_WRS) : W'(T_RDS);
      end
      PH_STROBE: if (zero && (!modem || rdy_s)) begin
        nxt = PH_HOLD; load = 1'b1; len = W'(T_HOLD);
      end
      PH_HOLD: if (zero) begin
        nxt = PH_RECOV; load = 1'b1; len = wr_q ? W'(T_WREC) : W'(T_RREC);
      end
      PH_RECOV: if (zero) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      phase  <= nxt;
      done_q <= (phase == PH_RECOV) && (nxt == PH_IDLE);
      if (phase == PH_IDLE && start) wr_q <= start_wr;
    end
  end

  assign phase_o  = phase;
  assign wr_o     = wr_q;
  assign sample_o = (phase == PH_STROBE) && (nxt == PH_HOLD) && !wr_q;
  assign done_o   = done_q;
  assign busy_o   = (phase != PH_IDLE);

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: done only follows a running cycle
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(phase) == PH_RECOV);

  // R2: a new cycle only starts from idle
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> $past(phase) == PH_IDLE);
endmodule

// File: rtl/flbus_ctrl.sv
module flbus_ctrl
  import fbc_pkg::*;
#(
  parameter int          AW          = 17,
  parameter int          DW          = 8,
  parameter int          RDY_BIT     = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CLK_NS      = 40,
  parameter int unsigned ACC_NS      = 150,
  parameter int unsigned OE_NS       = 120,
  parameter int unsigned FLOAT_NS    = 50,
  parameter int unsigned WEL_NS      = 120,
  parameter int unsigned WEH_NS      = 25,
  parameter int unsigned AHOLD_NS    = 200,
  parameter int unsigned CSW_NS      = 30,
  parameter int unsigned DHOLD_NS    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          modem_mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rdy_pin_oe,
  input  logic          bus_rdy_i,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe,
  input  logic [DW-1:0] bus_dq_i
);
  // Derived phase lengths in clock cycles
  localparam int unsigned T_SETUP = umax(1, ns_to_cyc(CSW_NS, CLK_NS));
  localparam int unsigned T_RDS   = umax(ns_to_cyc(OE_NS, CLK_NS),
                                         remain(ns_to_cyc(ACC_NS, CLK_NS), T_SETUP));
  localparam int unsigned T_WRS   = umax(ns_to_cyc(WEL_NS, CLK_NS),
                                         remain(ns_to_cyc(ACC_NS, CLK_NS), T_SETUP));
  localparam int unsigned T_HOLD  = umax(1, umax(ns_to_cyc(CSW_NS, CLK_NS),
                                                 ns_to_cyc(DHOLD_NS, CLK_NS)));
  localparam int unsigned T_RREC  = umax(1, ns_to_cyc(FLOAT_NS, CLK_NS));
  localparam int unsigned T_WREC  = umax(umax(1, ns_to_cyc(WEH_NS, CLK_NS)),
                                         remain(ns_to_cyc(AHOLD_NS, CLK_NS), T_WRS + T_HOLD));
  localparam int unsigned T_MAX   = umax(umax(T_SETUP, T_HOLD),
                                         umax(umax(T_RDS, T_WRS), umax(T_RREC, T_WREC)));
  localparam int          CW      = $clog2(T_MAX + 1) + 1;
  localparam int          MW      = 8;

  phase_t        phase;
  logic          wr, sample, rdy_s, accept;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;

  // Named internal events
  logic cs_act, strobe_act;

  assign accept = req_valid && !busy;

  fbc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_rdy_i), .q(rdy_s)
  );

  fbc_seq #(
    .T_SETUP(T_SETUP), .T_RDS(T_RDS), .T_WRS(T_WRS), .T_HOLD(T_HOLD),
    .T_RREC(T_RREC), .T_WREC(T_WREC), .W(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
    .modem(modem_mode), .rdy_s(rdy_s), .phase_o(phase), .wr_o(wr),
    .sample_o(sample), .done_o(done), .busy_o(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (sample) rd_q <= bus_dq_i;
    end
  end

  assign cs_act     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe_act = (phase == PH_STROBE);

  assign bus_cs_n  = !cs_act;
  assign bus_oe_n  = !(strobe_act && !wr);
  assign bus_we_n  = !(strobe_act && wr);
  assign bus_dq_oe = cs_act && wr;
  assign bus_dq_o  = wdata_q;
  assign rd_data   = rd_q;
  assign bus_rdy_pin_oe = !modem_mode;

  for (genvar g = 0; g < AW; g++) begin : g_addr
    if (g == RDY_BIT) begin : g_shared
      assign bus_addr_o[g] = modem_mode ? 1'b0 : addr_q[g];
    end else begin : g_plain
      assign bus_addr_o[g] = addr_q[g];
    end
  end

  // Run-length monitors for the timing assertions
  logic [MW-1:0] we_run, oe_run, float_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run    <= '0;
      oe_run    <= '0;
      float_run <= '1;
    end else begin
      we_run    <= !bus_we_n ? ((we_run == '1) ? we_run : we_run + MW'(1)) : '0;
      oe_run    <= !bus_oe_n ? ((oe_run == '1) ? oe_run : oe_run + MW'(1)) : '0;
      float_run <= !bus_oe_n ? '0 : ((float_run == '1) ? float_run : float_run + MW'(1));
    end
  end

  // R3: a strobe is only active inside chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

  // R3: read strobe lasts at least its minimum
  p_oe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n) |-> oe_run >= MW'(T_RDS));

  // R5: the two strobes never overlap
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  // R5: write strobe lasts at least its minimum
  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> we_run >= MW'(T_WRS));

  // R4: no drive while the device may be driving
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_dq_oe);

  // R4: bus float time after the read strobe ends
  p_float_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dq_oe) |-> float_run >= MW'(T_RREC));

  // R2: address is frozen while a cycle runs
  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: tb/flbus_ctrl_test.sv
module flbus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        modem_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [16:0] bus_addr_o;
  logic        bus_rdy_pin_oe;
  logic        bus_rdy_i = 1'b1;
  logic        bus_cs_n, bus_oe_n, bus_we_n;
  logic [7:0]  bus_dq_o;
  logic        bus_dq_oe;
  logic [7:0]  bus_dq_i = '0;

  int total = 0;
  int bad = 0;

  flbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .modem_mode(modem_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr_o(bus_addr_o), .bus_rdy_pin_oe(bus_rdy_pin_oe), .bus_rdy_i(bus_rdy_i),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
  );

  always #4 clk = ~clk;

  // Expected timing from the nanosecond limits at a 40 ns period
  function automatic int up(input int ns);
    return (ns + 39) / 40;
  endfunction
  localparam int E_CS_FIRST = 1;
  int e_set, e_rds, e_wrs, e_hold, e_rrec, e_wrec;

  // Measurements of the last access
  int m_cs_first, m_cs_len, m_st_first, m_st_len, m_dq_len, m_done_at, m_done_cnt;
  int m_addr_bad, m_dq_bad, m_busy_bad;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Issue one request and sample every falling edge until done.
  task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input int rdy_rel, input bit swap_din, input bit inject);
    logic [16:0] exp_a;
    exp_a = a;
    if (modem_mode) exp_a[8] = 1'b0;
    m_cs_first = 0; m_cs_len = 0; m_st_first = 0; m_st_len = 0; m_dq_len = 0;
    m_done_at = 0; m_done_cnt = 0; m_addr_bad = 0; m_dq_bad = 0; m_busy_bad = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (inject && i == 3) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
      end
      if (inject && i == 4) req_valid = 1'b0;
      if (swap_din && i == 4) bus_dq_i = d;
      if (swap_din && i == 5) bus_dq_i = ~d;
      if (!bus_cs_n) begin
        m_cs_len++;
        if (m_cs_first == 0) m_cs_first = i;
      end
      if (wr ? !bus_we_n : !bus_oe_n) begin
        m_st_len++;
        if (m_st_first == 0) m_st_first = i;
        if (rdy_rel > 0 && m_st_len == rdy_rel) bus_rdy_i = 1'b1;
      end
      if (bus_dq_oe) begin
        m_dq_len++;
        if (bus_dq_o != d) m_dq_bad++;
      end
      if (bus_addr_o != exp_a) m_addr_bad++;
      if (!done && !busy) m_busy_bad++;
      if (done) begin
        m_done_at = i;
        m_done_cnt++;
        break;
      end
    end
    // one more sample: done must have dropped, nothing restarted
    @(negedge clk);
    if (done) m_done_cnt++;
    if (!bus_cs_n) m_cs_len++;
  endtask

  task automatic t_reset;
    chk("R1", "cs_n", bus_cs_n, 1);
    chk("R1", "oe_n", bus_oe_n, 1);
    chk("R1", "we_n", bus_we_n, 1);
    chk("R1", "dq_oe", bus_dq_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rd_data", rd_data, 0);
  endtask

  task automatic t_flash_read;
    modem_mode = 1'b0;
    bus_dq_i = 8'h11;
    access(1'b0, 17'h0_0123, 8'hC3, 0, 1'b1, 1'b0);
    chk("R3", "cs first sample", m_cs_first, E_CS_FIRST);
    chk("R3", "oe first sample", m_st_first, E_CS_FIRST + e_set);
    chk("R3", "oe length", m_st_len, e_rds);
    chk("R3", "rd_data captured at last strobe edge", rd_data, 8'hC3);
    chk("R4", "data driven during read", m_dq_len, 0);
    chk("R4", "cs length", m_cs_len, e_set + e_rds + e_hold);
    chk("R4", "done sample", m_done_at, e_set + e_rds + e_hold + e_rrec + 1);
    chk("R7", "done pulses", m_done_cnt, 1);
    chk("R7", "busy drop before done", m_busy_bad, 0);
    chk("R9", "address pins", m_addr_bad, 0);
  endtask

  task automatic t_flash_write;
    modem_mode = 1'b0;
    access(1'b1, 17'h1_0155, 8'hA7, 0, 1'b0, 1'b0);
    chk("R5", "cs first sample", m_cs_first, E_CS_FIRST);
    chk("R5", "we first sample", m_st_first, E_CS_FIRST + e_set);
    chk("R5", "we length", m_st_len, e_wrs);
    chk("R5", "cs length", m_cs_len, e_set + e_wrs + e_hold);
    chk("R5", "data drive length", m_dq_len, e_set + e_wrs + e_hold);
    chk("R5", "data value mismatches", m_dq_bad, 0);
    chk("R6", "done sample", m_done_at, e_set + e_wrs + e_hold + e_wrec + 1);
    chk("R7", "done pulses", m_done_cnt, 1);
    // R6: address stays after completion
    repeat (3) @(negedge clk);
    chk("R6", "address after done", bus_addr_o, 17'h1_0155);
    chk("R6", "cs idle after done", bus_cs_n, 1);
  endtask

  task automatic t_busy_ignored;
    modem_mode = 1'b0;
    access(1'b1, 17'h0_0F0F, 8'h3C, 0, 1'b0, 1'b1);
    chk("R2", "address changes during cycle", m_addr_bad, 0);
    chk("R2", "done pulses", m_done_cnt, 1);
    chk("R2", "cs after dropped request", m_cs_len, e_set + e_wrs + e_hold);
    repeat (4) @(negedge clk);
    chk("R2", "no late cycle (cs_n)", bus_cs_n, 1);
    chk("R2", "address kept", bus_addr_o, 17'h0_0F0F);
  endtask

  task automatic t_modem_stretch;
    modem_mode = 1'b1;
    @(negedge clk);
    chk("R8", "shared pin drive enable", bus_rdy_pin_oe, 0);
    bus_rdy_i = 1'b0;
    bus_dq_i = 8'h6E;
    access(1'b0, 17'h1_01AB, 8'h00, 5, 1'b0, 1'b0);
    chk("R8", "stretched oe length", m_st_len, 5 + 2);
    chk("R8", "done sample", m_done_at, e_set + 7 + e_hold + e_rrec + 1);
    chk("R8", "bit 8 held low", m_addr_bad, 0);
    chk("R8", "read data", rd_data, 8'h6E);
    bus_rdy_i = 1'b0;
    access(1'b1, 17'h0_0042, 8'h99, 4, 1'b0, 1'b0);
    chk("R8", "stretched we length", m_st_len, 4 + 2);
    bus_rdy_i = 1'b1;
    access(1'b1, 17'h0_0043, 8'h98, 0, 1'b0, 1'b0);
    chk("R8", "ready high gives minimum", m_st_len, e_wrs);
  endtask

  task automatic t_flash_ignores_ready;
    modem_mode = 1'b0;
    bus_rdy_i = 1'b0;
    @(negedge clk);
    chk("R9", "shared pin drive enable", bus_rdy_pin_oe, 1);
    access(1'b0, 17'h0_0100, 8'h00, 0, 1'b0, 1'b0);
    chk("R9", "oe length with ready low", m_st_len, e_rds);
    chk("R9", "bit 8 driven from address", m_addr_bad, 0);
    chk("R9", "bit 8 value", bus_addr_o[8], 1);
    bus_rdy_i = 1'b1;
  endtask

  initial begin
    e_set  = (up(30) > 1) ? up(30) : 1;
    e_rds  = (up(120) > up(150) - e_set) ? up(120) : up(150) - e_set;
    e_wrs  = (up(120) > up(150) - e_set) ? up(120) : up(150) - e_set;
    e_hold = (up(30) > up(10)) ? up(30) : up(10);
    e_rrec = up(50);
    e_wrec = (up(25) > up(200) - e_wrs - e_hold) ? up(25) : up(200) - e_wrs - e_hold;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flash_read();
    t_flash_write();
    t_busy_ignored();
    t_modem_stretch();
    t_flash_ignores_ready();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule